// File: doc/BRIEF.md
# Shared-Curve Degamma Table with Clamp Tail

This block linearises pixel components before a colour matrix. It holds one 35-entry table of 17-bit values in U1.16 format. Entries 0 to 32 are the knots of a piecewise-linear curve across the input range [0, 1.0). Entries 33 and 34 form a clamp tail for inputs at or above 1.0. The same table serves all pixel channels, so every channel follows one curve.

Software fills the table through two ports. The first is an index register whose write carries a start position and an auto-increment flag. The second is a data port that stores one entry per write. A write to the index register that sets the auto-increment flag turns auto-increment on and leaves the current position unchanged, whatever index it carries. Software therefore writes index 0 on its own first, and then writes again with the flag set.

Each channel input is a 17-bit U1.16 value. The block picks the bracketing pair of entries, blends them linearly by the low input bits, and registers the result. The result appears one cycle after the input.

Top module: `dg_top`

## Requirements
- R1: Reset loads the linear curve. Entry i (i ≤ 32) holds i·65536/32, and entries 33 and 34 hold 0x10000. After reset, out_valid is 0 and out_pix is 0.
- R2: An index write (idx_wr=1) with idx_auto=0 sets the write position to min(idx_val, 35) and turns auto-increment off.
- R3: An index write with idx_auto=1 turns auto-increment on, keeps the write position, and ignores idx_val.
- R4: A data write (data_wr=1) stores data_val at the current position. With auto-increment on, the position then advances by one. With auto-increment off, the position stays where it is.
- R5: A data write while the position is 35 changes no entry. Neither the position nor any entry goes past 35 or past entry 34.
- R6: For an input with bit 16 = 0, the segment is s = bits[15:11] and the weight is w = bits[10:0]. The output is floor((e[s]·(2048−w) + e[s+1]·w) / 2048).
- R7: For an input with bit 16 = 1, the output blends entry 33 and entry 34 with the weight w = bits[10:0], using the same formula as R6.
- R8: All channels read the same table. Channel c occupies bits [17c+16:17c] of pix_in and out_pix.
- R9: out_valid equals pix_valid delayed by one cycle. out_pix is updated only in cycles where pix_valid was 1, and it holds otherwise.
- R10: When idx_wr and data_wr are both 1 in the same cycle, the index write takes effect and the data write is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_wr | input | 1 | Index register write strobe |
| idx_val | input | 6 | Start position carried by an index write |
| idx_auto | input | 1 | Auto-increment flag of an index write |
| data_wr | input | 1 | Data port write strobe |
| data_val | input | 17 | Entry value, U1.16 |
| pix_valid | input | 1 | Pixel input valid |
| pix_in | input | 51 | Three 17-bit U1.16 channel inputs |
| out_valid | output | 1 | Result valid |
| out_pix | output | 51 | Three 17-bit linearised channel results |

## Verification
The assertions watch the write-position machinery on every cycle:
- the bound on the position,
- how an index write loads or keeps the position,
- the advance after an auto-increment data write,
- the one-cycle valid latency.

The interpolated values, the effect of ignored writes on the stored curve, and the fact that all channels share one curve show only at the pixel outputs. The bench sweeps the input range against its own model of the table, once for the default curve and again after reloads that include a descending segment.

// File: rtl/dg_pkg.sv
package dg_pkg;
  // Entry and input format: U1.16
  localparam int FRAC_W    = 16;
  localparam int ENT_W     = FRAC_W + 1;
  localparam int SEG_W     = 5;
  localparam int WT_W      = FRAC_W - SEG_W;
  localparam int CURVE_PTS = (1 << SEG_W) + 1;
  localparam int CLAMP_PTS = 2;
  localparam int TBL_N     = CURVE_PTS + CLAMP_PTS;
  localparam int PTR_W     = $clog2(TBL_N + 1);
  localparam int ACC_W     = ENT_W + WT_W + 1;
  localparam int ONE       = 1 << FRAC_W;

  typedef logic [ENT_W-1:0] entry_t;
  typedef logic [ACC_W-1:0] acc_t;

  // Value loaded at reset: straight line on the knots, unity on the tail
  function automatic entry_t linear_entry(input int i);
    if (i < CURVE_PTS) return entry_t'((i * ONE) / (CURVE_PTS - 1));
    return entry_t'(ONE);
  endfunction

  // Weighted mix of two neighbouring entries
  function automatic entry_t blend(input entry_t lo, input entry_t hi,
                                   input logic [WT_W-1:0] w);
    logic [WT_W:0] wc;
    acc_t          acc;
    wc  = (WT_W+1)'(1 << WT_W) - (WT_W+1)'(w);
    acc = acc_t'(lo) * acc_t'(wc) + acc_t'(hi) * acc_t'(w);
    return acc[WT_W +: ENT_W];
  endfunction
endpackage

// File: rtl/dg_ptr_ctrl.sv
module dg_ptr_ctrl
  import dg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idx_wr,
  input  logic [PTR_W-1:0] idx_val,
  input  logic             idx_auto,
  input  logic             data_wr,
  output logic [PTR_W-1:0] ptr,
  output logic             auto_on,
  output logic             we
);
  localparam logic [PTR_W-1:0] END_POS = PTR_W'(TBL_N);

  logic in_range;
  assign in_range = (ptr < END_POS);
  // the index write wins over a data write in the same cycle
  assign we = data_wr && !idx_wr && in_range;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr     <= '0;
      auto_on <= 1'b0;
    end else if (idx_wr) begin
      auto_on <= idx_auto;
      if (!idx_auto)
        ptr <= (idx_val > END_POS) ? END_POS : idx_val;
    end else if (we && auto_on) begin
      ptr <= ptr + 1'b1;
    end
  end
endmodule

// File: rtl/dg_table.sv
module dg_table
  import dg_pkg::*;
#(
  parameter int NRD = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [PTR_W-1:0] waddr,
  input  entry_t           wdata,
  input  logic [PTR_W-1:0] rd_addr [NRD],
  output entry_t           rd_data [NRD]
);
  entry_t mem [TBL_N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < TBL_N; i++) mem[i] <= linear_entry(i);
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rd_data[r] = (rd_addr[r] < PTR_W'(TBL_N)) ? mem[rd_addr[r]] : '0;
  end
endmodule

// File: rtl/dg_lane.sv
module dg_lane
  import dg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_valid,
  input  entry_t           pix,
  output logic [PTR_W-1:0] addr_lo,
  output logic [PTR_W-1:0] addr_hi,
  input  entry_t           ent_lo,
  input  entry_t           ent_hi,
  output entry_t           res
);
  logic            over;
  logic [WT_W-1:0] wt;

  assign over    = pix[FRAC_W];
  assign wt      = pix[WT_W-1:0];
  assign addr_lo = over ? PTR_W'(CURVE_PTS) : PTR_W'(pix[FRAC_W-1 -: SEG_W]);
  assign addr_hi = addr_lo + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n)         res <= '0;
    else if (pix_valid) res <= blend(ent_lo, ent_hi, wt);
  end
endmodule

// File: rtl/dg_top.sv
module dg_top
  import dg_pkg::*;
#(
  parameter int CHANNELS = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      idx_wr,
  input  logic [5:0]                idx_val,
  input  logic                      idx_auto,
  input  logic                      data_wr,
  input  logic [16:0]               data_val,
  input  logic                      pix_valid,
  input  logic [CHANNELS*17-1:0]    pix_in,
  output logic                      out_valid,
  output logic [CHANNELS*17-1:0]    out_pix
);
  localparam int NRD = 2 * CHANNELS;

  // named internal events for the checker
  logic [PTR_W-1:0] wr_ptr;
  logic             auto_on;
  logic             tbl_we;

  logic [PTR_W-1:0] rd_addr [NRD];
  entry_t           rd_data [NRD];

  dg_ptr_ctrl u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .idx_wr  (idx_wr),
    .idx_val (idx_val),
    .idx_auto(idx_auto),
    .data_wr (data_wr),
    .ptr     (wr_ptr),
    .auto_on (auto_on),
    .we      (tbl_we)
  );

  dg_table #(.NRD(NRD)) u_tbl (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (tbl_we),
    .waddr  (wr_ptr),
    .wdata  (data_val),
    .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_lane
    dg_lane u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .pix_valid(pix_valid),
      .pix      (pix_in[ch*ENT_W +: ENT_W]),
      .addr_lo  (rd_addr[2*ch]),
      .addr_hi  (rd_addr[2*ch+1]),
      .ent_lo   (rd_data[2*ch]),
      .ent_hi   (rd_data[2*ch+1]),
      .res      (out_pix[ch*ENT_W +: ENT_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= pix_valid;
  end
endmodule

// File: rtl/dg_check.sv
module dg_check
  import dg_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             idx_wr,
  input logic [5:0]       idx_val,
  input logic             idx_auto,
  input logic             data_wr,
  input logic             pix_valid,
  input logic             out_valid,
  input logic [PTR_W-1:0] wr_ptr,
  input logic             auto_on
);
  localparam logic [PTR_W-1:0] END_POS = PTR_W'(TBL_N);

  assert_ptr_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ptr <= END_POS);

  assert_idx_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_wr && !idx_auto) |=>
      (wr_ptr == (($past(idx_val) > END_POS) ? END_POS : $past(idx_val))) && !auto_on);

  assert_idx_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_wr && idx_auto) |=> $stable(wr_ptr) && auto_on);

  assert_auto_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!idx_wr && data_wr && auto_on && wr_ptr < END_POS) |=> wr_ptr == $past(wr_ptr) + 1'b1);

  assert_no_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!idx_wr && wr_ptr == END_POS) |=> wr_ptr == END_POS);

  assert_valid_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> out_valid);

  assert_valid_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> !out_valid);
endmodule

bind dg_top dg_check u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .idx_wr   (idx_wr),
  .idx_val  (idx_val),
  .idx_auto (idx_auto),
  .data_wr  (data_wr),
  .pix_valid(pix_valid),
  .out_valid(out_valid),
  .wr_ptr   (wr_ptr),
  .auto_on  (auto_on)
);

// File: tb/dg_top_bench.sv
module dg_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        idx_wr = 1'b0;
  logic [5:0]  idx_val = '0;
  logic        idx_auto = 1'b0;
  logic        data_wr = 1'b0;
  logic [16:0] data_val = '0;
  logic        pix_valid = 1'b0;
  logic [50:0] pix_in = '0;
  logic        out_valid;
  logic [50:0] out_pix;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  longint model [35];

  always #5 clk = ~clk;

  dg_top u_dg_top (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .idx_val(idx_val),
    .idx_auto(idx_auto), .data_wr(data_wr), .data_val(data_val),
    .pix_valid(pix_valid), .pix_in(pix_in), .out_valid(out_valid),
    .out_pix(out_pix)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected curve value: start knot plus floored fraction of the step
  function automatic longint expect_val(input int v);
    int s, w;
    longint step;
    s = (v >= 65536) ? 33 : ((v >> 11) & 31);
    w = v & 2047;
    step = model[s+1] - model[s];
    return model[s] + ((step * w) >>> 11);
  endfunction

  task automatic idx_write(input int v, input bit au);
    @(negedge clk);
    idx_wr = 1'b1; idx_val = 6'(v); idx_auto = au;
    @(negedge clk);
    idx_wr = 1'b0;
  endtask

  task automatic dat_write(input int d);
    @(negedge clk);
    data_wr = 1'b1; data_val = 17'(d);
    @(negedge clk);
    data_wr = 1'b0;
  endtask

  // channel c receives its own value; all must follow the one curve (R8)
  task automatic pix_check(input int v, input string req);
    int vc [3];
    for (int c = 0; c < 3; c++) begin
      vc[c] = (v + c * 7919) % 131072;
      pix_in[c*17 +: 17] = 17'(vc[c]);
    end
    pix_valid = 1'b1;
    @(negedge clk);
    pix_valid = 1'b0;
    check({req, " R9 valid"}, out_valid, 1);
    for (int c = 0; c < 3; c++)
      check({req, " R8 channel"}, out_pix[c*17 +: 17], expect_val(vc[c]));
  endtask

  initial begin
    for (int i = 0; i < 35; i++) model[i] = (i <= 32) ? (i * 2048) : 65536;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset valid", out_valid, 0);
    check("R1 reset data", out_pix, 0);

    // default curve: identity below 1.0, unity above
    for (int v = 0; v < 131072; v += 97) pix_check(v, "R1 R6 R7 default");
    pix_check(65535, "R6 top");
    pix_check(131071, "R7 over");

    // start at 0, then auto with a junk index (R3)
    idx_write(0, 0);
    idx_write(20, 1);
    for (int i = 0; i < 35; i++) begin
      int d;
      d = (i <= 32) ? i * i * 64 : ((i == 33) ? 'h1F000 : 'h1FFFF);
      dat_write(d);
      model[i] = d;
    end
    dat_write('h0ABCD);   // past the end: dropped (R5)
    for (int v = 0; v < 131072; v += 61) pix_check(v, "R4 R6 R7 loaded");
    pix_check(32'h1F800, "R7 tail mid");
    pix_check(32'h1FFFF, "R5 last entry kept");

    // non-auto writes overwrite one position (R2), descending segment
    idx_write(5, 0);
    dat_write('h2000);
    dat_write('h3000);
    model[5] = 'h3000;
    pix_check(5 << 11, "R2 overwrite");
    pix_check(6 << 11, "R2 neighbour kept");
    pix_check((5 << 11) + 1024, "R6 descending");
    pix_check((5 << 11) + 2047, "R6 descending end");

    // out-of-range index clamps; data then ignored (R5)
    idx_write(40, 0);
    dat_write('h00111);
    for (int k = 0; k < 35; k++) pix_check((k <= 32) ? (k << 11) : 65536 + (k - 33) * 2047, "R5 knots");

    // simultaneous index and data: data dropped (R10)
    @(negedge clk);
    idx_wr = 1'b1; idx_val = 6'd7; idx_auto = 1'b0;
    data_wr = 1'b1; data_val = 17'h00055;
    @(negedge clk);
    idx_wr = 1'b0; data_wr = 1'b0;
    pix_check(7 << 11, "R10 dropped");
    dat_write('h04444);
    model[7] = 'h04444;
    pix_check(7 << 11, "R10 later write");

    // hold when not valid (R9)
    pix_check(12345, "R9 prime");
    pix_in = '1;
    @(negedge clk);
    check("R9 idle valid", out_valid, 0);
    for (int c = 0; c < 3; c++)
      check("R9 hold", out_pix[c*17 +: 17], expect_val((12345 + c * 7919) % 131072));

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule